// File: doc/BRIEF.md
# Display Window Update Sequencer

This block drives a small LCD controller through a byte-wide command port. A host hands it a rectangle (inclusive column and row bounds) and then a stream of 16-bit RGB565 pixels. The block turns that into the controller's update sequence. First comes a column-range command with its four coordinate bytes. Then a row-range command with its four bytes. Then a memory-write command, followed by every pixel as two data bytes.

Each byte on the output carries a flag that tells a command byte (0) from a data byte (1). The byte moves over a valid/ready handshake to the serial or parallel link that follows. Two inputs, a column offset and a row offset, are added to the bounds so that a panel mounted off the controller's origin is addressed correctly. A byte-swap input reverses the order of the two bytes of each pixel. A blank request paints the whole panel black without taking any pixel input.

Top module: `lcd_window_writer`

## Requirements
- R1: After a request is accepted, the first eleven output bytes are: command 0x2A (flag 0), four data bytes (flag 1), command 0x2B (flag 0), four data bytes (flag 1), command 0x2C (flag 0). A byte with flag 0 is always one of these three codes.
- R2: Each group of four coordinate bytes is ordered start high byte, start low byte, end high byte, end low byte. The end value is the inclusive last column or row.
- R3: `cfg_left` is added modulo 2^16 to both column bounds and `cfg_top` to both row bounds. A carry from the low byte shows in the high byte.
- R4: After 0x2C the block consumes exactly (x1-x0+1)*(y1-y0+1) pixels from the pixel port and emits two flag-1 bytes per pixel. With `cfg_swap`=0 the high byte (bits 15:8) goes first.
- R5: With `cfg_swap`=1 the low byte (bits 7:0) of each pixel goes first.
- R6: A blank request sends column bounds 0..PANEL_W-1 and row bounds 0..PANEL_H-1, each plus its offset. It then sends PANEL_W*PANEL_H pixels of value zero. `pix_ready` stays low for the whole request.
- R7: `busy` rises on the edge that accepts `req_valid` and stays high until the last byte has been taken. A `req_valid` seen while `busy` is high has no effect: no extra bytes are produced.
- R8: `done` is high for exactly one cycle, starting at the edge that takes the last byte. `busy` is low in that same cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_dc` hold their values.
- R10: After reset, `busy`, `done`, `out_valid` and `pix_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an update (taken when idle) |
| req_blank | input | 1 | Request is a full-panel blank |
| req_x0 | input | 16 | First column |
| req_x1 | input | 16 | Last column (inclusive) |
| req_y0 | input | 16 | First row |
| req_y1 | input | 16 | Last row (inclusive) |
| cfg_left | input | 16 | Column offset, sampled with the request |
| cfg_top | input | 16 | Row offset, sampled with the request |
| cfg_swap | input | 1 | Low pixel byte first, sampled with the request |
| pix_valid | input | 1 | Pixel word available |
| pix_data | input | 16 | RGB565 pixel |
| pix_ready | output | 1 | Pixel word taken this cycle when valid |
| out_valid | output | 1 | Output byte valid |
| out_dc | output | 1 | 0 = command byte, 1 = data byte |
| out_byte | output | 8 | Output byte |
| out_ready | input | 1 | Downstream takes the byte |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse when the update has fully left |

## Verification
The assertions rely on a few assumptions about the inputs:
- Each end bound is at least its start bound, so the pixel count is never zero and the down-counter cannot pass zero.
- `out_ready` may drop at any time.
- `pix_valid` may gap freely.

The stimulus keeps to these. Every rectangle has x1 >= x0 and y1 >= y0. The downstream ready and the pixel valid are toggled by fixed periodic patterns, which also exercise the hold-under-stall property. Offsets are chosen so that low-byte carries occur.

// File: rtl/lws_pkg.sv
package lws_pkg;
  localparam int COORD_W = 16;
  localparam int PIX_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int HDR_LEN = 11;

  localparam logic [BYTE_W-1:0] OP_COLS = 8'h2A;
  localparam logic [BYTE_W-1:0] OP_ROWS = 8'h2B;
  localparam logic [BYTE_W-1:0] OP_MEMW = 8'h2C;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_PIX_HI,
    PH_PIX_LO,
    PH_DRAIN
  } phase_e;
endpackage

// File: rtl/lws_hdr_mux.sv
module lws_hdr_mux
  import lws_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [COORD_W-1:0] col_lo,
  input  logic [COORD_W-1:0] col_hi,
  input  logic [COORD_W-1:0] row_lo,
  input  logic [COORD_W-1:0] row_hi,
  output logic [BYTE_W-1:0]  hb,
  output logic               hb_dc
);
  localparam int HB = COORD_W - 1;
  localparam int LB = COORD_W - BYTE_W - 1;

  always_comb begin
    hb_dc = 1'b1;
    hb    = '0;
    case (idx)
      IDX_W'(0):  begin hb = OP_COLS; hb_dc = 1'b0; end
      IDX_W'(1):  hb = col_lo[HB:LB+1];
      IDX_W'(2):  hb = col_lo[BYTE_W-1:0];
      IDX_W'(3):  hb = col_hi[HB:LB+1];
      IDX_W'(4):  hb = col_hi[BYTE_W-1:0];
      IDX_W'(5):  begin hb = OP_ROWS; hb_dc = 1'b0; end
      IDX_W'(6):  hb = row_lo[HB:LB+1];
      IDX_W'(7):  hb = row_lo[BYTE_W-1:0];
      IDX_W'(8):  hb = row_hi[HB:LB+1];
      IDX_W'(9):  hb = row_hi[BYTE_W-1:0];
      IDX_W'(10): begin hb = OP_MEMW; hb_dc = 1'b0; end
      default:    begin hb = '0; hb_dc = 1'b1; end
    endcase
  end
endmodule

// File: rtl/lws_pix_split.sv
module lws_pix_split
  import lws_pkg::*;
#(
  parameter int LANES = PIX_W / BYTE_W
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic              swap,
  output logic [BYTE_W-1:0] first_b,
  output logic [BYTE_W-1:0] second_b
);
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = pix[g*BYTE_W +: BYTE_W];
  end

  assign first_b  = swap ? lane[0] : lane[LANES-1];
  assign second_b = swap ? lane[LANES-1] : lane[0];
endmodule

// File: rtl/lws_pix_ctr.sv
module lws_pix_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (dec) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign last = (remain == CNT_W'(1));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    dec |-> remain != '0);
endmodule

// File: rtl/lcd_window_writer.sv
module lcd_window_writer
  import lws_pkg::*;
#(
  parameter int PANEL_W = 240,
  parameter int PANEL_H = 320
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_blank,
  input  logic [15:0]         req_x0,
  input  logic [15:0]         req_x1,
  input  logic [15:0]         req_y0,
  input  logic [15:0]         req_y1,
  input  logic [15:0]         cfg_left,
  input  logic [15:0]         cfg_top,
  input  logic                cfg_swap,
  input  logic                pix_valid,
  input  logic [15:0]         pix_data,
  output logic                pix_ready,
  output logic                out_valid,
  output logic                out_dc,
  output logic [7:0]          out_byte,
  input  logic                out_ready,
  output logic                busy,
  output logic                done
);
  localparam int CNT_W = 2 * COORD_W;
  localparam int IDX_W = $clog2(HDR_LEN + 1);
  localparam logic [CNT_W-1:0]   BLANK_CNT = CNT_W'(PANEL_W * PANEL_H);
  localparam logic [COORD_W-1:0] LAST_COL  = COORD_W'(PANEL_W - 1);
  localparam logic [COORD_W-1:0] LAST_ROW  = COORD_W'(PANEL_H - 1);

  phase_e             phase;
  logic [IDX_W-1:0]   hdr_idx;
  logic [COORD_W-1:0] col_lo, col_hi, row_lo, row_hi;
  logic               blank_q, swap_q;
  logic [BYTE_W-1:0]  second_q;

  logic [COORD_W-1:0] span_x, span_y;
  logic [CNT_W-1:0]   area;
  logic               accept;
  logic               slot_free;
  logic               want, load_byte;
  logic [BYTE_W-1:0]  nxt_byte;
  logic               nxt_dc;
  logic [BYTE_W-1:0]  hb, first_b, second_b;
  logic               hb_dc;
  logic               ctr_dec, ctr_last;

  assign span_x    = req_x1 - req_x0 + COORD_W'(1);
  assign span_y    = req_y1 - req_y0 + COORD_W'(1);
  assign area      = CNT_W'(span_x) * CNT_W'(span_y);
  assign accept    = (phase == PH_IDLE) && req_valid;
  assign slot_free = !out_valid || out_ready;

  lws_hdr_mux #(.IDX_W(IDX_W)) hdr_i (
    .idx    (hdr_idx),
    .col_lo (col_lo),
    .col_hi (col_hi),
    .row_lo (row_lo),
    .row_hi (row_hi),
    .hb     (hb),
    .hb_dc  (hb_dc)
  );

  lws_pix_split split_i (
    .pix      (pix_data),
    .swap     (swap_q),
    .first_b  (first_b),
    .second_b (second_b)
  );

  assign ctr_dec = (phase == PH_PIX_LO) && slot_free;

  lws_pix_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (req_blank ? BLANK_CNT : area),
    .dec      (ctr_dec),
    .last     (ctr_last)
  );

  always_comb begin
    want     = 1'b0;
    nxt_byte = '0;
    nxt_dc   = 1'b1;
    case (phase)
      PH_HDR: begin
        want     = 1'b1;
        nxt_byte = hb;
        nxt_dc   = hb_dc;
      end
      PH_PIX_HI: begin
        want     = blank_q || pix_valid;
        nxt_byte = blank_q ? '0 : first_b;
      end
      PH_PIX_LO: begin
        want     = 1'b1;
        nxt_byte = second_q;
      end
      default: want = 1'b0;
    endcase
  end

  assign load_byte = slot_free && want;
  assign pix_ready = (phase == PH_PIX_HI) && !blank_q && slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      hdr_idx   <= '0;
      col_lo    <= '0;
      col_hi    <= '0;
      row_lo    <= '0;
      row_hi    <= '0;
      blank_q   <= 1'b0;
      swap_q    <= 1'b0;
      second_q  <= '0;
      out_valid <= 1'b0;
      out_dc    <= 1'b0;
      out_byte  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load_byte) begin
        out_valid <= 1'b1;
        out_byte  <= nxt_byte;
        out_dc    <= nxt_dc;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end

      case (phase)
        PH_IDLE: begin
          if (accept) begin
            col_lo  <= (req_blank ? '0 : req_x0) + cfg_left;
            col_hi  <= (req_blank ? LAST_COL : req_x1) + cfg_left;
            row_lo  <= (req_blank ? '0 : req_y0) + cfg_top;
            row_hi  <= (req_blank ? LAST_ROW : req_y1) + cfg_top;
            blank_q <= req_blank;
            swap_q  <= cfg_swap;
            hdr_idx <= '0;
            busy    <= 1'b1;
            phase   <= PH_HDR;
          end
        end
        PH_HDR: begin
          if (slot_free) begin
            hdr_idx <= hdr_idx + IDX_W'(1);
            if (hdr_idx == IDX_W'(HDR_LEN - 1)) phase <= PH_PIX_HI;
          end
        end
        PH_PIX_HI: begin
          if (load_byte) begin
            second_q <= blank_q ? '0 : second_b;
            phase    <= PH_PIX_LO;
          end
        end
        PH_PIX_LO: begin
          if (slot_free) phase <= ctr_last ? PH_DRAIN : PH_PIX_HI;
        end
        PH_DRAIN: begin
          if (out_valid && out_ready) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_cmd_code_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_dc) |->
      (out_byte == OP_COLS || out_byte == OP_ROWS || out_byte == OP_MEMW));

  p_no_pix_blank_r6: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> (busy && !blank_q));

  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  p_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(out_valid && out_ready)));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_byte) && $stable(out_dc)));
endmodule

// File: tb/lcd_window_writer_tb_top.sv
module lcd_window_writer_tb_top;
  localparam int PW = 8;
  localparam int PH = 6;
  localparam int QMAX = 512;

  typedef struct packed {
    logic        blank;
    logic        swap;
    logic [15:0] x0, x1, y0, y1, left, top;
    logic [3:0]  stall;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 16'd0,      16'd0,      16'd0,      16'd0,      16'h0000, 16'h0000, 4'd0},
    '{1'b0, 1'b0, 16'd2,      16'd4,      16'd1,      16'd2,      16'h0000, 16'h0000, 4'd1},
    '{1'b0, 1'b1, 16'd1,      16'd2,      16'd0,      16'd1,      16'h0120, 16'h0035, 4'd0},
    '{1'b1, 1'b0, 16'd0,      16'd0,      16'd0,      16'd0,      16'h0002, 16'h0001, 4'd2},
    '{1'b0, 1'b0, 16'h00FE,   16'h0101,   16'h0203,   16'h0203,   16'h0002, 16'h00FD, 4'd3},
    '{1'b1, 1'b1, 16'd0,      16'd0,      16'd0,      16'd0,      16'h0000, 16'h0000, 4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_blank = 1'b0, cfg_swap = 1'b0;
  logic [15:0] req_x0 = '0, req_x1 = '0, req_y0 = '0, req_y1 = '0;
  logic [15:0] cfg_left = '0, cfg_top = '0;
  logic pix_valid = 1'b0;
  logic [15:0] pix_data = '0;
  logic pix_ready, out_valid, out_dc, busy, done;
  logic [7:0] out_byte;
  logic out_ready = 1'b0;

  always #4 clk = ~clk;

  lcd_window_writer #(.PANEL_W(PW), .PANEL_H(PH)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_blank(req_blank),
    .req_x0(req_x0), .req_x1(req_x1), .req_y0(req_y0), .req_y1(req_y1),
    .cfg_left(cfg_left), .cfg_top(cfg_top), .cfg_swap(cfg_swap),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .out_valid(out_valid), .out_dc(out_dc), .out_byte(out_byte),
    .out_ready(out_ready), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [8:0] expq [QMAX];
  logic [8:0] capq [QMAX];
  int exp_n = 0, ncap = 0;
  int npix = 0, pix_idx = 0, ndone = 0, done_busy_err = 0, hold_err = 0;
  int stall = 0, cyc = 0;
  bit run = 1'b0, pend_pix = 1'b0, prev_stall = 1'b0;
  logic [8:0] prev_out = '0;

  function automatic logic [15:0] pval(int i);
    return 16'hC35A ^ (16'(i) * 16'h0123);
  endfunction

  task automatic check(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic build_exp(vec_t v);
    logic [15:0] xs, xe, ys, ye, p;
    xs = (v.blank ? 16'd0 : v.x0) + v.left;
    xe = (v.blank ? 16'(PW - 1) : v.x1) + v.left;
    ys = (v.blank ? 16'd0 : v.y0) + v.top;
    ye = (v.blank ? 16'(PH - 1) : v.y1) + v.top;
    npix = v.blank ? PW * PH : (int'(v.x1 - v.x0) + 1) * (int'(v.y1 - v.y0) + 1);
    expq[0]  = {1'b0, 8'h2A};
    expq[1]  = {1'b1, xs[15:8]};
    expq[2]  = {1'b1, xs[7:0]};
    expq[3]  = {1'b1, xe[15:8]};
    expq[4]  = {1'b1, xe[7:0]};
    expq[5]  = {1'b0, 8'h2B};
    expq[6]  = {1'b1, ys[15:8]};
    expq[7]  = {1'b1, ys[7:0]};
    expq[8]  = {1'b1, ye[15:8]};
    expq[9]  = {1'b1, ye[7:0]};
    expq[10] = {1'b0, 8'h2C};
    for (int i = 0; i < npix; i++) begin
      p = v.blank ? 16'h0000 : pval(i);
      expq[11 + 2*i] = {1'b1, v.swap ? p[7:0] : p[15:8]};
      expq[12 + 2*i] = {1'b1, v.swap ? p[15:8] : p[7:0]};
    end
    exp_n = 11 + 2 * npix;
  endtask

  // Handshake monitor and downstream / pixel source driver
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (pend_pix) pix_idx++;
      out_ready = run && ((stall == 0) || (cyc % (stall + 1) != 0));
      pix_valid = run && (pix_idx < npix) && !(stall != 0 && cyc % 5 == 2);
      pix_data  = pval(pix_idx);
      #1;
      if (prev_stall && (!out_valid || {out_dc, out_byte} != prev_out)) hold_err++;
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_dc, out_byte};
      if (out_valid && out_ready && ncap < QMAX) begin
        capq[ncap] = {out_dc, out_byte};
        ncap++;
      end
      pend_pix = pix_valid && pix_ready;
      if (done) begin
        ndone++;
        if (busy) done_busy_err++;
      end
    end
  end

  task automatic issue(vec_t v);
    @(negedge clk);
    req_blank = v.blank; cfg_swap = v.swap;
    req_x0 = v.x0; req_x1 = v.x1; req_y0 = v.y0; req_y1 = v.y1;
    cfg_left = v.left; cfg_top = v.top;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (ndone == 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic compare(string tag_hdr, string tag_pix, int first_pix);
    int bad_h, bad_p;
    bad_h = 0; bad_p = 0;
    for (int i = 0; i < 11; i++) if (capq[i] !== expq[i]) bad_h++;
    for (int i = 11; i < exp_n && i < QMAX; i++) if (capq[i] !== expq[i]) bad_p++;
    check(bad_h == 0, tag_hdr, bad_h, 0, "header byte mismatches");
    check(bad_p == 0, tag_pix, bad_p, 0, "pixel byte mismatches");
    if (first_pix >= 0)
      check(capq[11] == expq[11], tag_pix, int'(capq[11]), int'(expq[11]), "first pixel byte");
  endtask

  task automatic clear_run(int st);
    stall = st; ncap = 0; pix_idx = 0; ndone = 0; pend_pix = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R10 reset state
    check(busy == 1'b0, "R10", busy, 0, "busy after reset");
    check(done == 1'b0, "R10", done, 0, "done after reset");
    check(out_valid == 1'b0, "R10", out_valid, 0, "out_valid after reset");
    check(pix_ready == 1'b0, "R10", pix_ready, 0, "pix_ready after reset");

    // Vector walk: R1 R2 R3 header, R4 R5 R6 pixels, R8 done
    for (int k = 0; k < NVEC; k++) begin
      build_exp(VECS[k]);
      clear_run(int'(VECS[k].stall));
      run = 1'b1;
      issue(VECS[k]);
      wait_done();
      run = 1'b0;
      check(ncap == exp_n, "R4", ncap, exp_n, $sformatf("vec%0d byte count", k));
      compare(VECS[k].left != 0 ? "R3" : "R1", VECS[k].swap ? "R5" : "R4", -1);
      check(pix_idx == (VECS[k].blank ? 0 : npix), VECS[k].blank ? "R6" : "R4",
            pix_idx, VECS[k].blank ? 0 : npix, $sformatf("vec%0d pixels consumed", k));
      check(ndone == 1 && done_busy_err == 0, "R8", ndone, 1, $sformatf("vec%0d done pulses", k));
      check(busy == 1'b0, "R7", busy, 0, $sformatf("vec%0d busy after end", k));
    end

    // R2 explicit byte order on the carry vector (col start 0x0100)
    build_exp(VECS[4]);
    check(expq[1] == {1'b1, 8'h01} && expq[2] == {1'b1, 8'h00}, "R2", int'(expq[2]), 0, "model order");

    // R7: requests during busy are ignored
    build_exp(VECS[0]);
    clear_run(1);
    run = 1'b1;
    issue(VECS[0]);
    req_blank = 1'b1; req_valid = 1'b1;
    begin
      int t;
      t = 0;
      while (t < 2000) begin
        @(negedge clk);
        #2;
        if (done) break;
        t++;
      end
    end
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    run = 1'b0;
    check(ncap == exp_n, "R7", ncap, exp_n, "bytes with request held during busy");
    check(busy == 1'b0 && out_valid == 1'b0, "R7", busy, 0, "idle after ignored request");
    compare("R1", "R4", 0);

    // R9 output hold under backpressure
    check(hold_err == 0, "R9", hold_err, 0, "output changed while stalled");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule